// File: doc/BRIEF.md
# Standby Mode Wake-Up Controller

This block sits beside a processor core and manages the core's low-power halt states. The core asks to halt by pulsing a request together with a 2-bit standby mode. The controller then runs a short entry window. When the window ends, it gates the clock domains that the chosen mode switches off and raises a halted flag. A new interrupt request from a source that may wake the current mode ends the halt. All clocks return, and the pending interrupts are forwarded to the core one at a time in priority order.

In the two deepest modes, a request from the non-maskable source or from external interrupt 0 that arrives while entry is still in progress does not stop the entry. The request is latched as held, and the core completes its halt. Only a later fresh request wakes the core. The held request is then arbitrated against the newer one. The non-maskable source outranks every maskable level. Maskable sources carry a programmable level from 1 to 7, and level 0 disables a source.

Top module: `standby_wake_ctrl`

## Requirements
- R1: During and right after reset, halted_o is 0, clk_en_o is 4'b1111 and irq_valid_o is 0.
- R2: A halt_req_i pulse sampled while the core is running captures mode_i and starts a 5-cycle entry window. halted_o rises on the fifth rising edge after the edge that sampled the request. halt_req_i has no effect during the window or while halted.
- R3: clk_en_o bit 3 is the core clock, bit 2 the system clock, bit 1 the peripheral clock and bit 0 the oscillator. While halted_o is 0 the value is 4'b1111. While halted it depends on mode: mode 00 (light halt) gives 0111, 01 (idle-peripheral) gives 0011, 10 (idle-oscillator) gives 0001 and 11 (stop) gives 0000.
- R4: Wake sources are all enabled sources in modes 00 and 01, and only the non-maskable source and interrupt 0 in modes 10 and 11. A new request from a wake source while halted clears halted_o on the next edge. A request from any other source is recorded but leaves halted_o at 1.
- R5: In modes 00 and 01, a wake-source request during the entry window aborts entry on that edge, and halted_o does not rise.
- R6: In modes 10 and 11, a request during the entry window is held pending. Entry still completes, and a held request alone never ends the halt.
- R7: The non-maskable source is served before any maskable source. Among maskable sources the higher level (1 to 7) is served first. A source whose level is 0 is never captured.
- R8: On equal level, a request held during an entry window is served first. Otherwise the lower source id is served first.
- R9: irq_valid_o is 1 only while running with a request pending. An ack_i sampled with irq_valid_o retires the shown id, and the next winner is shown after that edge.
- R10: Source ids on irq_id_o are 0 for the non-maskable source, 1 for interrupt 0, and 2+k for irq_i[k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| halt_req_i | input | 1 | Halt request pulse from the core |
| mode_i | input | 2 | Standby mode sampled with the halt request |
| nmi_i | input | 1 | Non-maskable interrupt request pulse |
| int0_i | input | 1 | External interrupt 0 request pulse |
| int0_lvl_i | input | 3 | Priority level of interrupt 0 (0 disables) |
| irq_i | input | NUM_EXT | Other maskable request pulses |
| irq_lvl_i | input | 3*NUM_EXT | Levels of irq_i, 3 bits per source |
| ack_i | input | 1 | Core accepts the forwarded interrupt |
| halted_o | output | 1 | Core fully halted |
| clk_en_o | output | 4 | Clock enables: core, system, peripheral, oscillator |
| irq_valid_o | output | 1 | An interrupt is forwarded to the core |
| irq_id_o | output | ID_W | Id of the forwarded interrupt |

## Verification
A halt request counts from the edge that samples it: halted_o and the reduced clock enables follow five edges later, so the bench checks "not halted" after the fourth of those edges and "halted" after the fifth. A wake request, an abort during the window, and the retirement of a forwarded id through ack_i all show after the single edge that samples them, because irq_valid_o, irq_id_o and clk_en_o are decoded combinationally from registered state. The bench changes inputs on falling edges and reads outputs on the next falling edge. Each read therefore sees exactly one more rising edge than the step before it.

// File: rtl/swc_pkg.sv
package swc_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ENTER = 2'd1,
    ST_HALT  = 2'd2
  } swc_state_e;

  localparam logic [1:0] MODE_LIGHT = 2'b00;
  localparam logic [1:0] MODE_IDLE_P = 2'b01;
  localparam logic [1:0] MODE_IDLE_O = 2'b10;
  localparam logic [1:0] MODE_STOP = 2'b11;

  localparam int PRIO_W = 4;
  localparam logic [PRIO_W-1:0] PRIO_NMI = 4'd8;

  // enables while halted: {core, sys, periph, osc}
  function automatic logic [3:0] halt_clk_en(input logic [1:0] m);
    case (m)
      MODE_LIGHT:  return 4'b0111;
      MODE_IDLE_P: return 4'b0011;
      MODE_IDLE_O: return 4'b0001;
      default:     return 4'b0000;
    endcase
  endfunction

  // deep modes hold requests during entry and wake only on nmi/int0
  function automatic logic deep_mode(input logic [1:0] m);
    return m[1];
  endfunction

endpackage

// File: rtl/swc_entry_fsm.sv
module swc_entry_fsm
  import swc_pkg::*;
#(
  parameter int WIN_CYC = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       halt_req_i,
  input  logic [1:0] mode_i,
  input  logic       wake_i,
  output swc_state_e state_o,
  output logic [1:0] mode_o
);
  localparam int CNT_W = $clog2(WIN_CYC + 1);

  swc_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
      mode_q  <= MODE_LIGHT;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (halt_req_i) begin
            state_q <= ST_ENTER;
            cnt_q   <= CNT_W'(WIN_CYC);
            mode_q  <= mode_i;
          end
        end
        ST_ENTER: begin
          if (wake_i && !deep_mode(mode_q)) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
          end else if (cnt_q <= CNT_W'(1)) begin
            state_q <= ST_HALT;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_HALT: begin
          if (wake_i) state_q <= ST_RUN;
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign state_o = state_q;
  assign mode_o  = mode_q;

endmodule

// File: rtl/swc_pend.sv
module swc_pend #(
  parameter int NSRC = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] set_i,
  input  logic            hold_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o,
  output logic [NSRC-1:0] held_o
);
  logic [NSRC-1:0] pend_q, held_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[i] <= 1'b0;
        held_q[i] <= 1'b0;
      end else if (clr_i[i]) begin
        pend_q[i] <= 1'b0;
        held_q[i] <= 1'b0;
      end else if (set_i[i]) begin
        pend_q[i] <= 1'b1;
        held_q[i] <= held_q[i] | hold_i;
      end
    end
  end

  assign pend_o = pend_q;
  assign held_o = held_q;

endmodule

// File: rtl/swc_arb.sv
module swc_arb
  import swc_pkg::*;
#(
  parameter int NSRC = 6,
  parameter int ID_W = 3
) (
  input  logic [NSRC-1:0]        pend_i,
  input  logic [NSRC-1:0]        held_i,
  input  logic [NSRC*PRIO_W-1:0] prio_i,
  output logic                   any_o,
  output logic [ID_W-1:0]        id_o
);
  localparam int KEY_W = PRIO_W + 1;

  logic [KEY_W-1:0] best_key, cur_key;

  // strict compare: lower index keeps a full tie
  always_comb begin
    any_o    = 1'b0;
    id_o     = '0;
    best_key = '0;
    cur_key  = '0;
    for (int i = 0; i < NSRC; i++) begin
      cur_key = {prio_i[i*PRIO_W +: PRIO_W], held_i[i]};
      if (pend_i[i] && (!any_o || cur_key > best_key)) begin
        any_o    = 1'b1;
        best_key = cur_key;
        id_o     = ID_W'(i);
      end
    end
  end

endmodule

// File: rtl/standby_wake_ctrl.sv
module standby_wake_ctrl
  import swc_pkg::*;
#(
  parameter int NUM_EXT = 4,
  parameter int WIN_CYC = 5,
  parameter int NSRC    = NUM_EXT + 2,
  parameter int ID_W    = $clog2(NSRC)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 halt_req_i,
  input  logic [1:0]           mode_i,
  input  logic                 nmi_i,
  input  logic                 int0_i,
  input  logic [2:0]           int0_lvl_i,
  input  logic [NUM_EXT-1:0]   irq_i,
  input  logic [NUM_EXT*3-1:0] irq_lvl_i,
  input  logic                 ack_i,
  output logic                 halted_o,
  output logic [3:0]           clk_en_o,
  output logic                 irq_valid_o,
  output logic [ID_W-1:0]      irq_id_o
);
  swc_state_e              state_w;
  logic [1:0]              mode_w;
  logic [NSRC-1:0]         req_w, en_w, set_w, clr_w, wmask_w;
  logic [NSRC-1:0]         pend_w, held_w;
  logic [NSRC*PRIO_W-1:0]  prio_w;
  logic                    wake_w, hold_w, any_w;

  assign req_w[0] = nmi_i;
  assign en_w[0]  = 1'b1;
  assign prio_w[PRIO_W-1:0] = PRIO_NMI;
  assign req_w[1] = int0_i;
  assign en_w[1]  = |int0_lvl_i;
  assign prio_w[2*PRIO_W-1:PRIO_W] = {1'b0, int0_lvl_i};

  for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
    assign req_w[k+2] = irq_i[k];
    assign en_w[k+2]  = |irq_lvl_i[k*3 +: 3];
    assign prio_w[(k+2)*PRIO_W +: PRIO_W] = {1'b0, irq_lvl_i[k*3 +: 3]};
  end

  assign set_w = req_w & en_w;

  // deep modes wake only from nmi and int0
  assign wmask_w = deep_mode(mode_w) ? NSRC'(2'b11) : '1;
  assign wake_w  = |(set_w & wmask_w);
  assign hold_w  = (state_w == ST_ENTER) && deep_mode(mode_w);

  for (genvar i = 0; i < NSRC; i++) begin : g_clr
    assign clr_w[i] = ack_i && irq_valid_o && (irq_id_o == ID_W'(i));
  end

  swc_entry_fsm #(.WIN_CYC(WIN_CYC)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .halt_req_i (halt_req_i),
    .mode_i     (mode_i),
    .wake_i     (wake_w),
    .state_o    (state_w),
    .mode_o     (mode_w)
  );

  swc_pend #(.NSRC(NSRC)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_w),
    .hold_i (hold_w),
    .clr_i  (clr_w),
    .pend_o (pend_w),
    .held_o (held_w)
  );

  swc_arb #(.NSRC(NSRC), .ID_W(ID_W)) u_arb (
    .pend_i (pend_w),
    .held_i (held_w),
    .prio_i (prio_w),
    .any_o  (any_w),
    .id_o   (irq_id_o)
  );

  assign halted_o    = (state_w == ST_HALT);
  assign clk_en_o    = halted_o ? halt_clk_en(mode_w) : 4'b1111;
  assign irq_valid_o = (state_w == ST_RUN) && any_w;

endmodule

// File: rtl/swc_checker.sv
module swc_checker
  import swc_pkg::*;
#(
  parameter int NSRC = 6,
  parameter int ID_W = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            nmi_i,
  input logic            halted_o,
  input logic [3:0]      clk_en_o,
  input logic            irq_valid_o,
  input logic [ID_W-1:0] irq_id_o,
  input logic [1:0]      state_w,
  input logic [NSRC-1:0] pend_w
);

  assert_halt_after_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halted_o) |-> ($past(state_w) == 2'(ST_ENTER)));

  assert_core_clk_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !clk_en_o[3]);

  assert_awake_all_on_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halted_o |-> (clk_en_o == 4'b1111));

  assert_nmi_wakes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && nmi_i) |=> !halted_o);

  assert_nmi_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_valid_o && pend_w[0]) |-> (irq_id_o == '0));

  assert_valid_only_run_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> (!halted_o && state_w == 2'(ST_RUN)));

endmodule

bind standby_wake_ctrl swc_checker #(.NSRC(NSRC), .ID_W(ID_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .nmi_i       (nmi_i),
  .halted_o    (halted_o),
  .clk_en_o    (clk_en_o),
  .irq_valid_o (irq_valid_o),
  .irq_id_o    (irq_id_o),
  .state_w     (state_w),
  .pend_w      (pend_w)
);

// File: tb/standby_wake_ctrl_test.sv
`timescale 1ns/1ps
module standby_wake_ctrl_test;
  localparam int NUM_EXT = 4;
  localparam int ID_W = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic halt_req_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic nmi_i = 1'b0, int0_i = 1'b0;
  logic [2:0] int0_lvl_i = 3'd0;
  logic [NUM_EXT-1:0] irq_i = '0;
  logic [NUM_EXT*3-1:0] irq_lvl_i = '0;
  logic ack_i = 1'b0;
  logic halted_o, irq_valid_o;
  logic [3:0] clk_en_o;
  logic [ID_W-1:0] irq_id_o;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  standby_wake_ctrl #(.NUM_EXT(NUM_EXT), .WIN_CYC(5)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .halt_req_i(halt_req_i), .mode_i(mode_i),
    .nmi_i(nmi_i), .int0_i(int0_i), .int0_lvl_i(int0_lvl_i), .irq_i(irq_i),
    .irq_lvl_i(irq_lvl_i), .ack_i(ack_i), .halted_o(halted_o),
    .clk_en_o(clk_en_o), .irq_valid_o(irq_valid_o), .irq_id_o(irq_id_o)
  );

  // {mode, enables expected while halted}
  localparam logic [5:0] VEC [4] = '{
    {2'b00, 4'b0111}, {2'b01, 4'b0011}, {2'b10, 4'b0001}, {2'b11, 4'b0000}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  task automatic do_halt(input logic [1:0] m);
    halt_req_i = 1'b1; mode_i = m; tick(); halt_req_i = 1'b0;
  endtask

  task automatic do_ack();
    ack_i = 1'b1; tick(); ack_i = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected 0 cycles left", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    tick(); tick();
    check("R1 halted in reset", halted_o, 0);
    check("R1 clk_en in reset", clk_en_o, 4'b1111);
    check("R1 valid in reset", irq_valid_o, 0);
    rst_ni = 1'b1;
    tick();
    check("R1 valid after reset", irq_valid_o, 0);

    // table: halt in every mode, then wake with nmi
    for (int v = 0; v < 4; v++) begin
      do_halt(VEC[v][5:4]);
      for (int t = 0; t < 4; t++) tick();
      check("R2 window not yet halted", halted_o, 0);
      tick();
      check("R2 halted after window", halted_o, 1);
      check("R3 halted clock enables", clk_en_o, VEC[v][3:0]);
      check("R9 no forward while halted", irq_valid_o, 0);
      nmi_i = 1'b1; tick(); nmi_i = 1'b0;
      check("R4 nmi wakes", halted_o, 0);
      check("R3 clocks restored", clk_en_o, 4'b1111);
      check("R10 nmi id", irq_id_o, 0);
      do_ack();
      check("R9 retired", irq_valid_o, 0);
    end

    // R7 level order, R8 lower id on tie, R7 level 0 ignored
    irq_lvl_i = {3'd6, 3'd6, 3'd0, 3'd3};
    irq_i = 4'b1111; tick(); irq_i = '0;
    check("R7 highest level first", irq_id_o, 4);
    do_ack();
    check("R8 lower id on tie", irq_id_o, 5);
    do_ack();
    check("R7 lowest level last", irq_id_o, 2);
    do_ack();
    check("R7 level 0 never captured", irq_valid_o, 0);

    // R5 abort in idle-peripheral
    do_halt(2'b01);
    tick();
    irq_i[0] = 1'b1; tick(); irq_i = '0;
    check("R5 abort entry", halted_o, 0);
    check("R10 ext0 id", irq_id_o, 2);
    for (int t = 0; t < 5; t++) tick();
    check("R5 never halts", halted_o, 0);
    do_ack();

    // R6 hold in stop, R4 non-wake source, R2 ignored halt_req
    int0_lvl_i = 3'd3;
    irq_lvl_i[2:0] = 3'd5;
    do_halt(2'b11);
    tick();
    int0_i = 1'b1; tick(); int0_i = 1'b0;
    tick(); tick(); tick();
    check("R6 entry completes despite int0", halted_o, 1);
    check("R6 stop enables", clk_en_o, 4'b0000);
    tick(); tick(); tick();
    check("R6 held does not wake", halted_o, 1);
    irq_i[0] = 1'b1; tick(); irq_i = '0;
    tick();
    check("R4 ext source no wake in stop", halted_o, 1);
    halt_req_i = 1'b1; mode_i = 2'b00; tick(); halt_req_i = 1'b0;
    tick();
    check("R2 halt_req ignored while halted", clk_en_o, 4'b0000);
    nmi_i = 1'b1; tick(); nmi_i = 1'b0;
    check("R4 nmi wake from stop", halted_o, 0);
    check("R7 nmi over held", irq_id_o, 0);
    do_ack();
    check("R7 level 5 before 3", irq_id_o, 2);
    do_ack();
    check("R9 held int0 follows", irq_id_o, 1);
    do_ack();
    check("R9 all retired", irq_valid_o, 0);

    // R8 held wins tie in idle-oscillator, R4 int0 wakes
    int0_lvl_i = 3'd4;
    irq_lvl_i[5:3] = 3'd4;
    do_halt(2'b10);
    tick();
    irq_i[1] = 1'b1; tick(); irq_i = '0;
    tick(); tick(); tick();
    check("R6 halted in idle-osc", halted_o, 1);
    check("R3 idle-osc enables", clk_en_o, 4'b0001);
    int0_i = 1'b1; tick(); int0_i = 1'b0;
    check("R4 int0 wakes idle-osc", halted_o, 0);
    check("R8 held first on tie", irq_id_o, 3);
    do_ack();
    check("R8 newer follows", irq_id_o, 1);
    do_ack();
    check("R9 empty", irq_valid_o, 0);

    summary();
    $finish;
  end
endmodule